// File: doc/BRIEF.md
# Smart card T=0 character receiver

This block receives characters from a smart card over a single shared, half-duplex I/O line that uses the T=0 convention. A character opens with a low start bit, carries eight data bits with the least significant bit first, and ends with an even parity bit. A guard interval of two bit times follows. An external baud generator supplies an oversampling tick, `TICKS_PER_BIT` pulses per bit time. The receiver finds the middle of each bit by waiting half a bit after it first sees the start edge, then one full bit for each bit after that.

When parity fails, the receiver tells the sender by pulling the line low for the first bit of the guard interval. It only ever drives the line low, through an open-drain enable. A good character goes into a holding register and raises a ready flag. A bad character is dropped, and a sticky parity-error flag is set. An inhibit mode suppresses the low pulse on the line and sets a sticky NACK flag instead. In that mode the bad character is still stored, but the ready flag is not raised. Every parity failure adds one to an 8-bit error count, which stops at 255 and clears when it is read. Software clears each sticky flag with its own one-cycle strobe.

Top module: `sc_t0_rx`

## Requirements
- R1: A character is a low start bit, then eight data bits with the least significant bit first, then a parity bit. The character is good when the XOR of the eight data bits and the parity bit is 0. A good character is loaded into `rx_data`, and `rx_ready` goes to 1.
- R2: On a parity failure with `nack_inhibit`=0, `drive_low` is 1 for one bit time, covering the first guard bit and not the second. `par_err` goes to 1. `rx_data` and `rx_ready` keep their previous values.
- R3: On a parity failure with `nack_inhibit`=1, `drive_low` stays 0. `nack_flag` goes to 1. The bad character is loaded into `rx_data`. `rx_ready` and `par_err` keep their previous values.
- R4: Each parity failure adds 1 to `err_count`, whether or not inhibit mode is on. The count stops at 255 and does not wrap.
- R5: A one-cycle `err_rd` strobe clears `err_count` to 0 on the next cycle. If a failure is counted in the same cycle, the count becomes 1.
- R6: `nack_flag` stays at 1 until a `rst_nack` strobe clears it. `par_err` stays at 1 until a `clr_parerr` strobe clears it. If a clear and a new setting event fall in the same cycle, the flag stays set.
- R7: A `rd_data` strobe clears `rx_ready` and leaves `rx_data` unchanged.
- R8: If the line is high again at the middle of a start bit, the start is treated as false. Nothing changes and the receiver goes back to waiting.
- R9: After reset, `drive_low`, `rx_data`, `rx_ready`, `par_err`, `nack_flag` and `err_count` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_in | input | 1 | Level of the shared I/O line, already synchronised to `clk` |
| baud_tick | input | 1 | Oversampling tick, `TICKS_PER_BIT` pulses per bit time |
| nack_inhibit | input | 1 | 1 = do not pull the line low on a parity failure |
| rd_data | input | 1 | Strobe: the holding register has been read; clears `rx_ready` |
| err_rd | input | 1 | Strobe: the error count has been read; clears `err_count` |
| rst_nack | input | 1 | Strobe: clears `nack_flag` |
| clr_parerr | input | 1 | Strobe: clears `par_err` |
| drive_low | output | 1 | Open-drain enable; 1 pulls the line low |
| rx_data | output | 8 | Receive holding register |
| rx_ready | output | 1 | A good character is waiting in `rx_data` |
| par_err | output | 1 | Sticky flag: a parity failure was signalled on the line |
| nack_flag | output | 1 | Sticky flag: a parity failure occurred in inhibit mode |
| err_count | output | 8 | Saturating count of parity failures |

## Verification
The assertions check on every cycle:
- the error count only holds, steps up by one or is cleared, and it stays at its ceiling once there;
- the sticky flags hold their value until their own strobe arrives;
- `drive_low` only starts right after the half bit that ends the parity bit;
- the ready flag only rises after a good character.

Only the bench's scenarios can show the rest. Those behaviours are:
- that the line is actually pulled low in the first guard bit and released in the second;
- that inhibit mode stores the bad byte;
- that a glitch on the line is rejected;
- that 257 failures leave a count of 255.

// File: rtl/sc_t0_pkg.sv
package sc_t0_pkg;

    localparam int DATA_BITS = 8;
    localparam int CNT_BITS  = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PAR    = 3'd3,
        ST_TAIL   = 3'd4,
        ST_GUARD1 = 3'd5,
        ST_GUARD2 = 3'd6
    } frm_state_e;

    typedef struct packed {
        logic [DATA_BITS-1:0] data;
        logic                 ok;
        logic                 inhibited;
    } char_result_t;

    // Even parity: data bits and parity bit XOR to zero.
    function automatic logic parity_good(input logic [DATA_BITS-1:0] d, input logic p);
        return ((^d) ^ p) == 1'b0;
    endfunction

    function automatic logic [CNT_BITS-1:0] sat_inc(input logic [CNT_BITS-1:0] v);
        return (v == {CNT_BITS{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/sc_t0_bit_timer.sv
module sc_t0_bit_timer #(
    parameter int TICKS_PER_BIT = 8,
    localparam int CW = $clog2(TICKS_PER_BIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    logic [CW-1:0] cnt_q;

    assign expire = tick && !restart && (cnt_q == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= expire ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sc_t0_framer.sv
module sc_t0_framer
    import sc_t0_pkg::*;
#(
    parameter int TICKS_PER_BIT = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         line_in,
    input  logic         tick,
    input  logic         nack_inhibit,
    output frm_state_e   state,
    output logic         char_done,
    output char_result_t char_res,
    output logic         drive_low
);
    localparam int CW   = $clog2(TICKS_PER_BIT + 1);
    localparam int HALF = TICKS_PER_BIT / 2;
    localparam int IW   = $clog2(DATA_BITS);

    frm_state_e           state_q;
    logic [DATA_BITS-1:0] shreg_q;
    logic [IW-1:0]        idx_q;
    logic                 nack_req_q;
    logic                 done_q;
    char_result_t         res_q;
    logic [CW-1:0]        limit;
    logic                 expire;

    always_comb begin
        case (state_q)
            ST_START, ST_TAIL: limit = CW'(HALF);
            default:           limit = CW'(TICKS_PER_BIT);
        endcase
    end

    sc_t0_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .restart (state_q == ST_IDLE),
        .limit   (limit),
        .expire  (expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            shreg_q    <= '0;
            idx_q      <= '0;
            nack_req_q <= 1'b0;
            done_q     <= 1'b0;
            res_q      <= '0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (tick && !line_in) state_q <= ST_START;
                end
                ST_START: begin
                    if (expire) begin
                        idx_q   <= '0;
                        state_q <= line_in ? ST_IDLE : ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (expire) begin
                        shreg_q <= {line_in, shreg_q[DATA_BITS-1:1]};
                        idx_q   <= idx_q + 1'b1;
                        if (idx_q == IW'(DATA_BITS - 1)) state_q <= ST_PAR;
                    end
                end
                ST_PAR: begin
                    if (expire) begin
                        done_q          <= 1'b1;
                        res_q.data      <= shreg_q;
                        res_q.ok        <= parity_good(shreg_q, line_in);
                        res_q.inhibited <= nack_inhibit;
                        nack_req_q      <= !parity_good(shreg_q, line_in) && !nack_inhibit;
                        state_q         <= ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (expire) state_q <= ST_GUARD1;
                end
                ST_GUARD1: begin
                    if (expire) state_q <= ST_GUARD2;
                end
                ST_GUARD2: begin
                    if (expire) begin
                        nack_req_q <= 1'b0;
                        state_q    <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state     = state_q;
    assign char_done = done_q;
    assign char_res  = res_q;
    assign drive_low = (state_q == ST_GUARD1) && nack_req_q;
endmodule

// File: rtl/sc_t0_err_counter.sv
module sc_t0_err_counter
    import sc_t0_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                inc,
    input  logic                clr,
    output logic [CNT_BITS-1:0] count
);
    logic [CNT_BITS-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= inc ? CNT_BITS'(1) : '0;
        end else if (inc) begin
            cnt_q <= sat_inc(cnt_q);
        end
    end

    assign count = cnt_q;
endmodule

// File: rtl/sc_t0_rx.sv
module sc_t0_rx
    import sc_t0_pkg::*;
#(
    parameter int TICKS_PER_BIT = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 line_in,
    input  logic                 baud_tick,
    input  logic                 nack_inhibit,
    input  logic                 rd_data,
    input  logic                 err_rd,
    input  logic                 rst_nack,
    input  logic                 clr_parerr,
    output logic                 drive_low,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_ready,
    output logic                 par_err,
    output logic                 nack_flag,
    output logic [CNT_BITS-1:0]  err_count
);
    frm_state_e           frm_state;
    logic                 char_done;
    char_result_t         char_res;
    logic [DATA_BITS-1:0] data_q;
    logic                 ready_q, par_err_q, nack_q;
    logic                 fail_evt;

    sc_t0_framer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_frm (
        .clk          (clk),
        .rst          (rst),
        .line_in      (line_in),
        .tick         (baud_tick),
        .nack_inhibit (nack_inhibit),
        .state        (frm_state),
        .char_done    (char_done),
        .char_res     (char_res),
        .drive_low    (drive_low)
    );

    assign fail_evt = char_done && !char_res.ok;

    sc_t0_err_counter u_errcnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (fail_evt),
        .clr   (err_rd),
        .count (err_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            ready_q   <= 1'b0;
            par_err_q <= 1'b0;
            nack_q    <= 1'b0;
        end else begin
            if (rd_data)    ready_q   <= 1'b0;
            if (clr_parerr) par_err_q <= 1'b0;
            if (rst_nack)   nack_q    <= 1'b0;
            if (char_done) begin
                if (char_res.ok) begin
                    data_q  <= char_res.data;
                    ready_q <= 1'b1;
                end else if (char_res.inhibited) begin
                    data_q <= char_res.data;
                    nack_q <= 1'b1;
                end else begin
                    par_err_q <= 1'b1;
                end
            end
        end
    end

    assign rx_data   = data_q;
    assign rx_ready  = ready_q;
    assign par_err   = par_err_q;
    assign nack_flag = nack_q;
endmodule

// File: rtl/sc_t0_rx_chk.sv
module sc_t0_rx_chk
    import sc_t0_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 drive_low,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_ready,
    input logic                 par_err,
    input logic                 nack_flag,
    input logic [CNT_BITS-1:0]  err_count,
    input logic                 err_rd,
    input logic                 rst_nack,
    input logic                 clr_parerr,
    input frm_state_e           frm_state,
    input logic                 char_done,
    input logic                 char_ok
);
    assert_sat_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (err_count == {CNT_BITS{1'b1}} && !err_rd) |=> err_count == {CNT_BITS{1'b1}});

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        !err_rd |=> (err_count == $past(err_count)) || (err_count == $past(err_count) + 1'b1));

    assert_read_clear_R5: assert property (@(posedge clk) disable iff (rst)
        err_rd |=> err_count <= CNT_BITS'(1));

    assert_nack_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (nack_flag && !rst_nack) |=> nack_flag);

    assert_parerr_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (par_err && !clr_parerr) |=> par_err);

    assert_drive_window_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(drive_low) |-> $past(frm_state) == ST_TAIL);

    assert_ready_source_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_ready) |-> ($past(char_done) && $past(char_ok)));

    assert_data_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !char_done |=> $stable(rx_data));
endmodule

bind sc_t0_rx sc_t0_rx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .drive_low  (drive_low),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .par_err    (par_err),
    .nack_flag  (nack_flag),
    .err_count  (err_count),
    .err_rd     (err_rd),
    .rst_nack   (rst_nack),
    .clr_parerr (clr_parerr),
    .frm_state  (frm_state),
    .char_done  (char_done),
    .char_ok    (char_res.ok)
);

// File: tb/sc_t0_rx_tb.sv
module sc_t0_rx_tb_top;
    localparam int TPB = 8;
    localparam int BT  = TPB * 2;   // clocks per bit: tick every 2 clocks

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx = 1'b1;
    logic baud_tick = 1'b0;
    logic nack_inhibit = 1'b0, rd_data = 1'b0, err_rd = 1'b0;
    logic rst_nack = 1'b0, clr_parerr = 1'b0;
    logic drive_low, rx_ready, par_err, nack_flag;
    logic [7:0] rx_data, err_count;
    logic line;

    int checks = 0, failures = 0;
    logic [7:0] m_data = 0, m_cnt = 0;
    logic m_ready = 0, m_par = 0, m_nack = 0;

    always #4 clk = ~clk;   // 125 MHz
    assign line = tx & ~drive_low;

    always @(posedge clk) baud_tick <= ~baud_tick;

    sc_t0_rx #(.TICKS_PER_BIT(TPB)) dut_i (
        .clk(clk), .rst(rst), .line_in(line), .baud_tick(baud_tick),
        .nack_inhibit(nack_inhibit), .rd_data(rd_data), .err_rd(err_rd),
        .rst_nack(rst_nack), .clr_parerr(clr_parerr), .drive_low(drive_low),
        .rx_data(rx_data), .rx_ready(rx_ready), .par_err(par_err),
        .nack_flag(nack_flag), .err_count(err_count)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sat(input logic [7:0] v);
        return (v == 8'hFF) ? v : v + 8'd1;
    endfunction

    task automatic check_all(input string tag);
        chk({tag, " rx_data"},   rx_data,   m_data);
        chk({tag, " rx_ready"},  rx_ready,  m_ready);
        chk({tag, " par_err"},   par_err,   m_par);
        chk({tag, " nack_flag"}, nack_flag, m_nack);
        chk({tag, " err_count"}, err_count, m_cnt);
    endtask

    task automatic send_char(input logic [7:0] d, input logic bad, input logic inh, input logic full_check);
        logic g1_low, g2_low;
        @(negedge clk);
        nack_inhibit = inh;
        tx = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            tx = d[i];
            repeat (BT) @(negedge clk);
        end
        tx = (^d) ^ bad;
        repeat (BT) @(negedge clk);
        tx = 1'b1;
        repeat (BT / 2) @(negedge clk);
        g1_low = !line;
        repeat (BT) @(negedge clk);
        g2_low = drive_low;
        repeat (BT / 2 + 16) @(negedge clk);
        if (bad) begin
            m_cnt = sat(m_cnt);
            if (inh) begin m_data = d; m_nack = 1'b1; end
            else m_par = 1'b1;
        end else begin
            m_data = d; m_ready = 1'b1;
        end
        if (full_check) begin
            chk(bad ? (inh ? "R3 guard1 line" : "R2 guard1 line") : "R1 guard1 line",
                g1_low, bad && !inh);
            chk("R2 guard2 released", g2_low, 0);
            check_all(bad ? (inh ? "R3" : "R2 R4") : "R1");
        end
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: begin rd_data = 1; m_ready = 0; end
            1: begin err_rd = 1; m_cnt = 0; end
            2: begin rst_nack = 1; m_nack = 0; end
            default: begin clr_parerr = 1; m_par = 0; end
        endcase
        @(negedge clk);
        rd_data = 0; err_rd = 0; rst_nack = 0; clr_parerr = 0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h5C70;
        void'($urandom(seed));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_all("R9 reset");
        chk("R9 reset drive_low", drive_low, 0);

        // directed
        send_char(8'hA5, 0, 0, 1);                       // R1
        pulse(0); chk("R7 rd_data clears ready", rx_ready, 0);
        chk("R7 rx_data kept", rx_data, 8'hA5);
        send_char(8'h3C, 1, 0, 1);                       // R2: data kept, par_err
        send_char(8'h81, 1, 1, 1);                       // R3: stored, no ready
        pulse(2); chk("R6 rst_nack clears", nack_flag, 0);
        chk("R6 par_err still set", par_err, 1);
        pulse(3); chk("R6 clr_parerr clears", par_err, 0);
        pulse(1); chk("R5 err_rd clears", err_count, 0);

        // false start glitch
        @(negedge clk); tx = 1'b0;
        repeat (2) @(negedge clk); tx = 1'b1;
        repeat (BT * 3) @(negedge clk);
        chk("R8 glitch no drive", drive_low, 0);
        check_all("R8 glitch");
        send_char(8'h5A, 0, 0, 1);                       // R8 recovers

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [7:0] d;
            d = 8'($urandom);
            send_char(d, ($urandom % 3) == 0, ($urandom % 2) == 1, 1);
            if (($urandom % 4) == 0) pulse(int'($urandom % 4));
        end

        // saturation
        pulse(1);
        for (int n = 0; n < 257; n++) send_char(8'($urandom), 1, 1, 0);
        chk("R4 saturates at 255", err_count, 255);
        check_all("R4 after saturation");
        pulse(1);
        chk("R5 clear after saturation", err_count, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule